// File: doc/BRIEF.md
# Photon-gated dual-counter demodulator

This block is the digital back end of one imaging pixel. It receives an asynchronous, active-low detection pulse from the photon front end and a global bin-select level that follows the light modulation. It sorts every detected photon into one of two phase bins. The falling edge of the pulse marks the arrival time. The pulse is brought into the clock domain, and that edge becomes a single-cycle event. The bin-select level then steers the event into one of two saturating counters.

A readout controller asserts a read enable to fetch both bin counts together as one word. It then issues a synchronous clear to start the next acquisition. When either counter reaches full scale, the pixel stops counting in both bins. It stays stopped until the next clear, so the two bins keep a valid ratio even in bright light.

Top module: `phase_bin_demod`

## Requirements
- R1: After reset both bin counts are zero, and with read enable high the output word reads 0x0000.
- R2: Each high-to-low transition of `photon_n` adds exactly one count. Holding `photon_n` low adds no further counts, and a low-to-high transition adds none.
- R3: An event that is counted while `bin_sel` is 0 increments bin 0, which is output bits [7:0]. An event counted while `bin_sel` is 1 increments bin 1, which is output bits [15:8].
- R4: While `read_en` is 0, `bins_out` is 0. While `read_en` is 1, `bins_out` carries bin 1 in bits [15:8] and bin 0 in bits [7:0], both in the same cycle.
- R5: When either bin count equals 255, further events change neither bin, whatever the state of `bin_sel`.
- R6: The frozen state persists across any number of events until `clear` is sampled high. After the clear, counting resumes normally.
- R7: When `clear` is sampled high, both bin counts become zero at that clock edge. An event that falls in the same cycle is discarded.
- R8: If `photon_n` falls before rising edge k, the new count is visible on `bins_out` after rising edge k+2 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| photon_n | input | 1 | Asynchronous detection pulse, active low |
| bin_sel | input | 1 | Phase bin select, synchronous to clk |
| clear | input | 1 | Synchronous clear of both bins and of the freeze |
| read_en | input | 1 | Drives the bin counts onto the output when high |
| bins_out | output | 16 | {bin 1, bin 0} when read, zero otherwise |

## Verification
The hardest condition to reach is the frozen pixel. A bin has to be filled to full scale one photon edge at a time, and the pulses must have enough high time between them to give separate synchronized edges. The bench therefore sends 255 spaced pulses into one bin and then aims further pulses at both bins. It does this once with bin 0 saturated and once with bin 1 saturated, while the other bin holds a nonzero count. A second hard case is a photon event landing in the same cycle as the clear. The bench reaches it by counting the two synchronizer stages and raising `clear` exactly on the cycle in which the edge event is live.

// File: rtl/phase_bin_demod.sv
module phase_bin_demod #(
  parameter int CNT_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               photon_n,
  input  logic               bin_sel,
  input  logic               clear,
  input  logic               read_en,
  output logic [2*CNT_W-1:0] bins_out
);

  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [CNT_W-1:0]       cnt0, cnt1;
  logic                   evt, frozen, bump0, bump1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], photon_n};
      prev_q <= sync_q[SYNC_STAGES-1];
    end

  assign evt    = prev_q & ~sync_q[SYNC_STAGES-1];
  assign frozen = (cnt0 == FULL) | (cnt1 == FULL);
  assign bump0  = evt & ~frozen & ~clear & ~bin_sel;
  assign bump1  = evt & ~frozen & ~clear &  bin_sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt0 <= '0;
      cnt1 <= '0;
    end else if (clear) begin
      cnt0 <= '0;
      cnt1 <= '0;
    end else begin
      if (bump0) cnt0 <= cnt0 + 1'b1;
      if (bump1) cnt1 <= cnt1 + 1'b1;
    end

  assign bins_out = read_en ? {cnt1, cnt0} : '0;

endmodule

// File: rtl/phase_bin_demod_chk.sv
module phase_bin_demod_chk #(
  parameter int CNT_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clear,
  input logic               bin_sel,
  input logic               read_en,
  input logic               evt,
  input logic [CNT_W-1:0]   cnt0,
  input logic [CNT_W-1:0]   cnt1,
  input logic [2*CNT_W-1:0] bins_out
);

  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt0 == '0) && (cnt1 == '0));

  a_r5_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && (cnt0 == FULL || cnt1 == FULL)) |=> $stable(cnt0) && $stable(cnt1));

  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> !(cnt0 != $past(cnt0) && cnt1 != $past(cnt1)));

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !evt) |=> $stable(cnt0) && $stable(cnt1));

  a_r3_steer_low: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !bin_sel && !clear && cnt0 != FULL && cnt1 != FULL)
      |=> cnt0 == CNT_W'($past(cnt0) + 1'b1) && $stable(cnt1));

  a_r3_steer_high: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && bin_sel && !clear && cnt0 != FULL && cnt1 != FULL)
      |=> cnt1 == CNT_W'($past(cnt1) + 1'b1) && $stable(cnt0));

  a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !read_en |-> bins_out == '0);

endmodule

bind phase_bin_demod phase_bin_demod_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .bin_sel(bin_sel),
  .read_en(read_en), .evt(evt), .cnt0(cnt0), .cnt1(cnt1), .bins_out(bins_out)
);

// File: tb/sim_phase_bin_demod.sv
`timescale 1ns/1ps
module sim_phase_bin_demod;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        photon_n = 1'b1;
  logic        bin_sel = 1'b0;
  logic        clear = 1'b0;
  logic        read_en = 1'b1;
  logic [15:0] bins_out;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  phase_bin_demod u0 (
    .clk(clk), .rst_n(rst_n), .photon_n(photon_n), .bin_sel(bin_sel),
    .clear(clear), .read_en(read_en), .bins_out(bins_out)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic sel);
    @(negedge clk);
    bin_sel = sel;
    photon_n = 1'b0;
    repeat (2) @(negedge clk);
    photon_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    read_en = 1'b1;
    chk("R1 reset value", bins_out, 16'h0000);
  endtask

  task automatic t_steer();
    do_clear();
    repeat (3) pulse(1'b0);
    repeat (5) pulse(1'b1);
    settle();
    chk("R3 steering both bins", bins_out, 16'h0503);
    pulse(1'b1);
    settle();
    chk("R3 steer to bin 1", bins_out, 16'h0603);
  endtask

  task automatic t_hold_low();
    do_clear();
    @(negedge clk);
    photon_n = 1'b0;
    bin_sel = 1'b0;
    repeat (20) @(negedge clk);
    chk("R2 one count while held low", bins_out, 16'h0001);
    photon_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R2 rising edge adds none", bins_out, 16'h0001);
  endtask

  task automatic t_latency();
    do_clear();
    @(negedge clk);
    bin_sel = 1'b1;
    photon_n = 1'b0;
    @(negedge clk);
    chk("R8 not after edge k", bins_out, 16'h0000);
    @(negedge clk);
    chk("R8 not after edge k+1", bins_out, 16'h0000);
    @(negedge clk);
    chk("R8 visible after edge k+2", bins_out, 16'h0100);
    photon_n = 1'b1;
    settle();
  endtask

  task automatic t_read_gate();
    do_clear();
    pulse(1'b0);
    pulse(1'b1);
    pulse(1'b1);
    settle();
    read_en = 1'b0;
    #1;
    chk("R4 output zero when not read", bins_out, 16'h0000);
    read_en = 1'b1;
    #1;
    chk("R4 both bins in one word", bins_out, 16'h0201);
  endtask

  task automatic t_sat_bin0();
    do_clear();
    repeat (2) pulse(1'b1);
    repeat (255) pulse(1'b0);
    settle();
    chk("R5 bin 0 reaches full", bins_out, 16'h02FF);
    repeat (3) pulse(1'b1);
    repeat (3) pulse(1'b0);
    settle();
    chk("R5 both frozen after bin 0 full", bins_out, 16'h02FF);
    repeat (200) @(negedge clk);
    pulse(1'b1);
    settle();
    chk("R6 freeze persists", bins_out, 16'h02FF);
    do_clear();
    chk("R6 clear releases", bins_out, 16'h0000);
    pulse(1'b1);
    settle();
    chk("R6 counting resumes", bins_out, 16'h0100);
  endtask

  task automatic t_sat_bin1();
    do_clear();
    repeat (10) pulse(1'b0);
    repeat (255) pulse(1'b1);
    settle();
    chk("R5 bin 1 reaches full", bins_out, 16'hFF0A);
    repeat (4) pulse(1'b0);
    settle();
    chk("R5 bin 0 frozen by bin 1 full", bins_out, 16'hFF0A);
  endtask

  task automatic t_clear_drop();
    do_clear();
    repeat (4) pulse(1'b0);
    settle();
    chk("R7 precondition", bins_out, 16'h0004);
    @(negedge clk);
    photon_n = 1'b0;
    bin_sel = 1'b0;
    @(negedge clk);
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    chk("R7 clear zeroes and drops event", bins_out, 16'h0000);
    repeat (3) @(negedge clk);
    chk("R7 dropped event stays lost", bins_out, 16'h0000);
    photon_n = 1'b1;
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_steer();
    t_hold_low();
    t_latency();
    t_read_gate();
    t_sat_bin0();
    t_sat_bin1();
    t_clear_drop();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule